// File: doc/BRIEF.md
# USB handshake interrupt filter

This block sits between the transaction engine of a USB device controller and the interrupt line to an external microprocessor. Each time a transaction ends, the engine reports the handshake (ACK, NAK or NYET), the endpoint number and the direction. It also reports a one-cycle pulse when a SETUP token arrives on endpoint 0. An 8-bit configuration register gives a separate filter mode to each of three endpoint classes: the control endpoint 0, the data IN endpoints and the data OUT endpoints. The block uses that mode to decide whether each handshake counts as an interrupt.

One filter mode passes only the first NAK. A per-endpoint, per-direction armed flag tracks this. A SETUP followed by an ACK on endpoint 0 re-arms every flag. An ACK on a data endpoint re-arms the flag for that endpoint and direction. Any NAK clears the flag it hits.

Qualified events drive the interrupt pin in one of two ways. In level mode, a pending bit stays set until the processor gives a one-cycle acknowledge. In pulse mode, each event produces a fixed-width pulse of `PULSE_CYCLES` clocks. Twelve clocks at 200 MHz give about 60 ns. Either polarity can be selected.

Top module: `usb_irq_filter`

## Requirements
- R1: After reset, the configuration reads 0x00 and int_o is high (idle, active-low level mode). No event or acknowledge arrives, and int_o stays high.
- R2: The configuration register loads cfg_wdata_i on a cycle with cfg_we_i high, and the new value appears on cfg_o on the next cycle. The fields are as follows: bits 7:6 hold the endpoint 0 mode, bits 5:4 the data IN mode and bits 3:2 the data OUT mode. Bit 1 selects the signalling (0 = level, 1 = pulse) and bit 0 selects the polarity (0 = active low, 1 = active high).
- R3: The handshake code on ev_kind_i is 00 for ACK, 01 for NAK, 10 for NYET and 11 for no handshake. An ACK qualifies on every endpoint in every mode. A NYET qualifies only on a data OUT endpoint (ev_ep_i 1 to 7, ev_in_i = 0). Code 11, a NYET elsewhere, or any event with ev_valid_i low leaves int_o unchanged.
- R4: With a class mode of 00, every NAK in that class qualifies. With a class mode of 01, no NAK qualifies.
- R5: With a class mode of 1X, a NAK qualifies only if the armed flag for its endpoint and direction (ev_ep_i, ev_in_i) is set. Every NAK clears that flag, whatever the mode. All flags are clear after reset.
- R6: A SETUP pulse (setup_i) followed by an ACK on endpoint 0 sets all armed flags and consumes the SETUP. An ACK on endpoint 0 with no SETUP before it sets no flag. An ACK on endpoint 1 to 7 sets the flag for that endpoint and direction. A SETUP in the same cycle as an endpoint 0 ACK applies only to a later ACK.
- R7: In level mode, a qualified event makes int_o active from the next cycle. The line stays active until irq_ack_i is high for one cycle, and becomes inactive on the cycle after that. If a qualified event arrives in the same cycle as the acknowledge, the line stays active.
- R8: In pulse mode, a qualified event makes int_o active for exactly PULSE_CYCLES cycles, starting on the next cycle. Events that arrive while a pulse is active neither stretch it nor queue a second pulse. Pulse-mode events do not set the level-mode pending bit.
- R9: int_o equals the internal active state when bit 0 is 1, and equals its inverse when bit 0 is 0. A polarity change takes effect on the cycle after the write.
- R10: An event in the same cycle as a register write is filtered and signalled using the configuration in effect before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_o | output | 8 | Current configuration value |
| ev_valid_i | input | 1 | Handshake event valid |
| ev_kind_i | input | 2 | Handshake code: 00 ACK, 01 NAK, 10 NYET, 11 none |
| ev_ep_i | input | 3 | Endpoint number of the event |
| ev_in_i | input | 1 | Event direction: 1 = IN, 0 = OUT |
| setup_i | input | 1 | SETUP token seen on endpoint 0 (one cycle) |
| irq_ack_i | input | 1 | Level-mode acknowledge (one cycle) |
| int_o | output | 1 | Interrupt pin |

## Verification
Two functions can fall in the same cycle: clearing the level-mode pending bit through irq_ack_i, and setting it through a new qualified handshake. A second same-cycle case is a register write that coincides with an event, which must be filtered under the old setting. Both cases are provoked by directed steps and then by a long pseudo-random stretch that drives writes, acknowledges, SETUP pulses and handshakes independently. The bench's behavioural model applies "set wins over clear" and "old configuration filters", and int_o and cfg_o are compared against it on every clock.

// File: rtl/usb_irq_pkg.sv
`timescale 1ns/1ps
package usb_irq_pkg;

  typedef enum logic [1:0] {
    HS_ACK  = 2'b00,
    HS_NAK  = 2'b01,
    HS_NYET = 2'b10,
    HS_NONE = 2'b11
  } hs_kind_e;

  // field order is the register bit order, msb first
  typedef struct packed {
    logic [1:0] ctrl_mode;
    logic [1:0] in_mode;
    logic [1:0] out_mode;
    logic       pulse_sel;
    logic       act_high;
  } irq_cfg_t;

  localparam logic [1:0] MODE_ALL_NAK = 2'b00;
  localparam logic [1:0] MODE_NO_NAK  = 2'b01;

endpackage

// File: rtl/usb_irq_cfg_reg.sv
`timescale 1ns/1ps
module usb_irq_cfg_reg
  import usb_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output irq_cfg_t   cfg_o
);

  irq_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= irq_cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;

  assert_cfg_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (8'(cfg_o) == $past(wdata_i)));

  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_o));

endmodule

// File: rtl/usb_irq_nak_arm.sv
`timescale 1ns/1ps
module usb_irq_nak_arm
  import usb_irq_pkg::*;
#(
  parameter int EP_NUM = 8,
  localparam int EP_W  = $clog2(EP_NUM),
  localparam int IDX_W = EP_W + 1,
  localparam int SLOTS = 2 * EP_NUM
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ev_valid_i,
  input  hs_kind_e        ev_kind_i,
  input  logic [EP_W-1:0] ev_ep_i,
  input  logic            ev_in_i,
  input  logic            setup_i,
  output logic            armed_o
);

  logic [IDX_W-1:0] idx;
  logic [SLOTS-1:0] flag_q;
  logic             setup_seen_q;
  logic             ack_ev, nak_ev, ep0_ack, rearm_all;

  assign idx       = {ev_in_i, ev_ep_i};
  assign ack_ev    = ev_valid_i && (ev_kind_i == HS_ACK);
  assign nak_ev    = ev_valid_i && (ev_kind_i == HS_NAK);
  assign ep0_ack   = ack_ev && (ev_ep_i == '0);
  assign rearm_all = ep0_ack && setup_seen_q;

  // a SETUP in the same cycle as an ep0 ACK waits for the next ACK
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      setup_seen_q <= 1'b0;
    else if (setup_i) setup_seen_q <= 1'b1;
    else if (ep0_ack) setup_seen_q <= 1'b0;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[g] <= 1'b0;
      else if (rearm_all) flag_q[g] <= 1'b1;
      else if (idx == SLOT) begin
        if (nak_ev)                            flag_q[g] <= 1'b0;
        else if (ack_ev && (ev_ep_i != '0))    flag_q[g] <= 1'b1;
      end
    end
  end

  assign armed_o = flag_q[idx];

  assert_nak_disarm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_ev |=> !flag_q[$past(idx)]);

  assert_rearm_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_all |=> (&flag_q));

  assert_data_ack_arm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_ev && (ev_ep_i != '0)) |=> flag_q[$past(idx)]);

endmodule

// File: rtl/usb_irq_pin_drv.sv
`timescale 1ns/1ps
module usb_irq_pin_drv #(
  parameter int PULSE_CYCLES = 12,
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic ack_i,
  input  logic pulse_sel_i,
  input  logic act_high_i,
  output logic int_o
);

  logic             pending_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active;

  // new event wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= 1'b0;
    else         pending_q <= (pending_q && !ack_i) || (hit_i && !pulse_sel_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
    else if (hit_i && pulse_sel_i) cnt_q <= CNT_W'(PULSE_CYCLES);
  end

  assign active = pulse_sel_i ? (cnt_q != '0) : pending_q;
  assign int_o  = act_high_i ? active : !active;

  assert_level_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !pulse_sel_i) |=> pending_q);

  assert_level_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !(hit_i && !pulse_sel_i)) |=> !pending_q);

  assert_pulse_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_pulse_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q == '0) && !(hit_i && pulse_sel_i)) |=> (cnt_q == '0));

endmodule

// File: rtl/usb_irq_filter.sv
`timescale 1ns/1ps
module usb_irq_filter
  import usb_irq_pkg::*;
#(
  parameter int EP_NUM       = 8,
  parameter int PULSE_CYCLES = 12,
  localparam int EP_W        = $clog2(EP_NUM)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [7:0]      cfg_wdata_i,
  output logic [7:0]      cfg_o,
  input  logic            ev_valid_i,
  input  logic [1:0]      ev_kind_i,
  input  logic [EP_W-1:0] ev_ep_i,
  input  logic            ev_in_i,
  input  logic            setup_i,
  input  logic            irq_ack_i,
  output logic            int_o
);

  irq_cfg_t   cfg;
  hs_kind_e   kind;
  logic       armed, hit, ep0;
  logic [1:0] mode;

  assign kind = hs_kind_e'(ev_kind_i);
  assign ep0  = (ev_ep_i == '0);

  usb_irq_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  usb_irq_nak_arm #(.EP_NUM(EP_NUM)) u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_valid_i (ev_valid_i),
    .ev_kind_i  (kind),
    .ev_ep_i    (ev_ep_i),
    .ev_in_i    (ev_in_i),
    .setup_i    (setup_i),
    .armed_o    (armed)
  );

  // qualification uses the registered config, i.e. the pre-write value
  always_comb begin
    mode = ep0 ? cfg.ctrl_mode : (ev_in_i ? cfg.in_mode : cfg.out_mode);
    hit  = 1'b0;
    if (ev_valid_i) begin
      unique case (kind)
        HS_ACK:  hit = 1'b1;
        HS_NYET: hit = !ep0 && !ev_in_i;
        HS_NAK: begin
          if (mode == MODE_ALL_NAK)     hit = 1'b1;
          else if (mode == MODE_NO_NAK) hit = 1'b0;
          else                          hit = armed;
        end
        default: hit = 1'b0;
      endcase
    end
  end

  usb_irq_pin_drv #(.PULSE_CYCLES(PULSE_CYCLES)) u_pin (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .ack_i       (irq_ack_i),
    .pulse_sel_i (cfg.pulse_sel),
    .act_high_i  (cfg.act_high),
    .int_o       (int_o)
  );

  assign cfg_o = cfg;

  assert_nyet_scope_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && (kind == HS_NYET) && (ep0 || ev_in_i)) |-> !hit);

  assert_idle_pin_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_valid_i && !cfg_we_i && !irq_ack_i && !$past(ev_valid_i) && $past(rst_ni)
     && $stable(cfg)) |=> $stable(int_o) || cfg.pulse_sel);

endmodule

// File: tb/sim_usb_irq_filter.sv
`timescale 1ns/1ps
module sim_usb_irq_filter;

  localparam int P = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] cfg_o;
  logic       v = 1'b0;
  logic [1:0] k = 2'b11;
  logic [2:0] ep = '0;
  logic       din = 1'b0;
  logic       su = 1'b0;
  logic       ak = 1'b0;
  logic       int_o;

  int compared = 0;
  int mismatched = 0;

  // behavioural model state
  bit         armed [16];
  bit         setup_seen = 0;
  bit         pending = 0;
  int         cnt = 0;
  logic [7:0] mcfg = '0;

  always #2.5 clk = ~clk;

  usb_irq_filter #(.EP_NUM(8), .PULSE_CYCLES(P)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wd), .cfg_o(cfg_o),
    .ev_valid_i(v), .ev_kind_i(k), .ev_ep_i(ep), .ev_in_i(din),
    .setup_i(su), .irq_ack_i(ak), .int_o(int_o)
  );

  function automatic bit model_hit(bit vv, int kk, int e, bit di);
    int m;
    if (!vv) return 0;
    m = (e == 0) ? int'(mcfg[7:6]) : (di ? int'(mcfg[5:4]) : int'(mcfg[3:2]));
    case (kk)
      0: return 1;
      2: return (e != 0) && !di;
      1: begin
        if (m == 0) return 1;
        if (m == 1) return 0;
        return armed[(di ? 8 : 0) + e];
      end
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(bit vv, int kk, int e, bit di, bit ss, bit aa, bit ww,
                     logic [7:0] wdat, string tag);
    bit h, act, n_setup, n_pend;
    bit n_armed [16];
    int n_cnt, slot;
    v = vv; k = 2'(kk); ep = 3'(e); din = di; su = ss; ak = aa; we = ww; wd = wdat;
    h = model_hit(vv, kk, e, di);
    slot = (di ? 8 : 0) + e;
    n_armed = armed;
    n_setup = setup_seen;
    if (vv && kk == 1) n_armed[slot] = 0;
    if (vv && kk == 0) begin
      if (e == 0) begin
        if (setup_seen) for (int i = 0; i < 16; i++) n_armed[i] = 1;
        n_setup = 0;
      end else n_armed[slot] = 1;
    end
    if (ss) n_setup = 1;
    n_pend = (pending && !aa) || (h && !mcfg[1]);
    if (cnt > 0) n_cnt = cnt - 1;
    else if (h && mcfg[1]) n_cnt = P;
    else n_cnt = 0;
    @(posedge clk);
    #1;
    armed = n_armed; setup_seen = n_setup; pending = n_pend; cnt = n_cnt;
    if (ww) mcfg = wdat;
    act = mcfg[1] ? (cnt != 0) : pending;
    check(tag, {7'd0, int_o}, {7'd0, mcfg[0] ? act : !act}, "int_o");
    check(tag, cfg_o, mcfg, "cfg_o");
  endtask

  task automatic idle(string tag);
    cyc(0, 3, 0, 0, 0, 0, 0, 8'h00, tag);
  endtask
  task automatic ev(int kk, int e, bit di, string tag);
    cyc(1, kk, e, di, 0, 0, 0, 8'h00, tag);
  endtask
  task automatic wr(logic [7:0] d, string tag);
    cyc(0, 3, 0, 0, 0, 0, 1, d, tag);
  endtask
  task automatic ackc(string tag);
    cyc(0, 3, 0, 0, 0, 1, 0, 8'h00, tag);
  endtask
  task automatic setup_p(string tag);
    cyc(0, 3, 0, 0, 1, 0, 0, 8'h00, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) armed[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {7'd0, int_o}, 8'h01, "int_o in reset");
    check("R1", cfg_o, 8'h00, "cfg_o in reset");
    rst_n = 1'b1;
    repeat (3) idle("R1");

    // default modes 00: ACK, NAK, NYET scope
    ev(0, 3, 1, "R3"); idle("R3"); ackc("R7"); idle("R7");
    ev(1, 0, 0, "R4"); ackc("R4");
    ev(2, 2, 0, "R3"); ackc("R3");
    ev(2, 2, 1, "R3"); idle("R3");
    ev(2, 0, 0, "R3"); idle("R3");
    ev(3, 4, 0, "R3"); idle("R3");
    cyc(0, 0, 5, 0, 0, 0, 0, 8'h00, "R3");

    // ACK-only modes
    wr(8'h54, "R2");
    ev(1, 0, 1, "R4"); ev(1, 1, 1, "R4"); ev(1, 1, 0, "R4"); idle("R4");
    ev(0, 6, 0, "R3"); ackc("R3");
    ev(2, 6, 0, "R3"); ackc("R3");

    // first-NAK modes
    wr(8'hA8, "R2");
    ev(1, 0, 1, "R5"); idle("R5");
    ev(0, 0, 0, "R6"); ackc("R6");
    ev(1, 0, 1, "R6"); idle("R6");
    setup_p("R6"); ev(0, 0, 0, "R6"); ackc("R6");
    ev(1, 0, 1, "R5"); ackc("R5");
    ev(1, 0, 1, "R5"); idle("R5");
    ev(1, 5, 0, "R5"); ackc("R5");
    ev(1, 5, 0, "R5"); idle("R5");
    ev(0, 5, 0, "R6"); ackc("R6");
    ev(1, 5, 0, "R6"); ackc("R6");
    ev(1, 5, 1, "R5"); idle("R5");
    cyc(1, 0, 0, 0, 1, 0, 0, 8'h00, "R6"); ackc("R6");
    ev(1, 3, 0, "R6"); idle("R6");
    ev(0, 0, 1, "R6"); ackc("R6");
    ev(1, 3, 0, "R6"); ackc("R6");

    // ack and new event in the same cycle
    wr(8'h00, "R7");
    ev(0, 1, 1, "R7");
    cyc(1, 0, 2, 1, 0, 1, 0, 8'h00, "R7"); idle("R7");
    ackc("R7"); idle("R7");

    // polarity
    wr(8'h01, "R9"); idle("R9");
    ev(1, 4, 1, "R9"); idle("R9"); ackc("R9"); idle("R9");
    ev(0, 1, 0, "R9"); wr(8'h00, "R9"); ackc("R9");

    // pulse mode
    wr(8'h03, "R8");
    ev(0, 2, 0, "R8");
    for (int i = 0; i < 4; i++) idle("R8");
    ev(0, 3, 0, "R8");
    for (int i = 0; i < P + 2; i++) idle("R8");
    ev(2, 7, 0, "R8"); ev(0, 7, 1, "R8");
    for (int i = 0; i < 2 * P; i++) idle("R8");
    wr(8'h02, "R8"); ev(1, 1, 1, "R8");
    for (int i = 0; i < P + 1; i++) idle("R8");

    // event in the cycle of a register write
    wr(8'h54, "R10");
    cyc(1, 1, 2, 0, 0, 0, 1, 8'h00, "R10"); idle("R10");
    cyc(1, 1, 2, 0, 0, 0, 1, 8'h54, "R10"); idle("R10"); ackc("R10");
    cyc(1, 0, 4, 1, 0, 0, 1, 8'h03, "R10"); idle("R10"); ackc("R10");
    for (int i = 0; i < P; i++) idle("R10");
    cyc(1, 0, 4, 1, 0, 0, 1, 8'h00, "R10");
    for (int i = 0; i < 3; i++) idle("R10");
    ackc("R10"); idle("R10");

    // mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      automatic bit          rv = ($urandom_range(0, 3) != 0);
      automatic int          rk = $urandom_range(0, 3);
      automatic int          re = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 7);
      automatic bit          rd = 1'($urandom_range(0, 1));
      automatic bit          rs = ($urandom_range(0, 9) == 0);
      automatic bit          ra = ($urandom_range(0, 5) == 0);
      automatic bit          rw = ($urandom_range(0, 39) == 0);
      automatic logic [7:0]  rdat = 8'($urandom);
      cyc(rv, rk, re, rd, rs, ra, rw, rdat, "R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule